// File: doc/BRIEF.md
# Circular-Buffer FIR Filter Sequencer

This block produces one output of an N-tap finite impulse response filter for every input sample it accepts. A new sample enters through a valid/ready handshake and is written into a small sample memory used as a circular delay line. The samples already in the line are never moved. Instead, a head pointer advances by one slot with power-of-two wrap-around, so it always marks the newest entry. A separate coefficient memory holds the taps, so the block can read both operands of a tap in the same clock.

After a sample is accepted, a hardware tap counter steps through the N taps at one tap per clock. The tap products pass through a three-stage pipeline: operand fetch register, multiply register, accumulate. The pipeline fills during the first cycles of the loop and drains after the last tap is issued. The accumulator starts from zero for every output. The finished sum appears as a single-cycle `result_valid` pulse. The handshake reopens in that same cycle, so the next sample can follow with no gap.

Coefficients are loaded through a plain write port. Coefficient slot k multiplies the sample that arrived k samples before the newest one.

Top module: `fir_circ_seq`

## Requirements
- R1: After reset, `sample_ready` is 1, `result_valid` is 0, and every sample slot and coefficient slot holds zero.
- R2: The result for a sample equals the sum over k = 0..N-1 of coef[k] times x[n-k]. Here x[n] is the sample just accepted, and delay-line slots that no accepted sample has written count as zero.
- R3: `result_valid` is high for exactly one cycle. That cycle begins at the (N+2)-th rising edge after the edge that accepted the sample.
- R4: `sample_ready` is 0 from the edge after an acceptance until the cycle in which `result_valid` is high, and is 1 in that cycle. A `sample_valid` presented while `sample_ready` is 0 is ignored: it changes neither the delay line nor any result.
- R5: The delay line holds exactly the last N accepted samples. A sample drops out of the sum once N newer samples have been accepted, and the head pointer wraps modulo N.
- R6: A sample presented in the same cycle as `result_valid` is accepted. Its result is computed from a cleared accumulator and does not include any earlier sum.
- R7: When `coef_we` is 1 at a rising edge, `coef_data` is stored in slot `coef_addr`. Results whose tap loop starts after that edge use the new value.
- R8: Samples and coefficients are signed two's complement. The result is the exact signed sum at full precision, with width DW+CW+log2(N)+1 bits, including the case where every sample and coefficient is the most negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | Input sample offered |
| sample_data | input | DW | Signed input sample |
| sample_ready | output | 1 | Block can accept a sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | TAP_LOG2 | Coefficient slot index (tap delay) |
| coef_data | input | CW | Signed coefficient value |
| result_valid | output | 1 | One-cycle strobe: result_data holds a finished sum |
| result_data | output | DW+CW+TAP_LOG2+1 | Signed filter output |

## Verification
Two functions can meet in one cycle: the drain of one output, where its sum is posted on `result_valid`, and the acceptance of the next sample, which restarts the tap counter and clears the accumulator for the next sum. The bench provokes this by driving `sample_valid` in the exact cycle that shows the result pulse. It then judges both results against a sum computed arithmetically from its own copy of the delay line. The first result must be unaffected, and the second must carry no trace of the first accumulation. The bench also holds `sample_valid` high with junk data while the block is busy, then checks that later sums show no sign of that junk.

// File: rtl/fir_pkg.sv
// Package: shared types for the circular-buffer FIR sequencer.
// Assumes nothing; holds the sequencer state encoding only.
package fir_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_t;
endpackage

// File: rtl/fir_delay_line.sv
// Module: circular sample store. Each write advances the head pointer one
// slot (modulo DEPTH) and stores the sample there; nothing is ever shifted.
// The read port returns the sample rd_ofs positions older than the newest.
// Assumes DEPTH is a power of two so the wrap is a plain truncation.
module fir_delay_line #(
    parameter int DW       = 8,
    parameter int TAP_LOG2 = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DW-1:0]       wr_data,
    input  logic [TAP_LOG2-1:0] rd_ofs,
    output logic [DW-1:0]       rd_data
);
    localparam int DEPTH = 1 << TAP_LOG2;

    logic [DW-1:0]       slot_q [DEPTH];
    logic [TAP_LOG2-1:0] head_q;
    logic [TAP_LOG2-1:0] head_nxt;
    logic [TAP_LOG2-1:0] rd_idx;

    // Next head slot: one past the newest, wrapping by truncation.
    always_comb head_nxt = head_q + 1'b1;

    // Read index: newest minus delay, modulo DEPTH.
    always_comb rd_idx = head_q - rd_ofs;

    // Head pointer update on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)     head_q <= '0;
        else if (wr_en) head_q <= head_nxt;
    end

    // One register per slot; only the slot under the new head is written.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && (head_nxt == TAP_LOG2'(g)))
                slot_q[g] <= wr_data;
        end
    end

    // Combinational read of the addressed slot.
    always_comb rd_data = slot_q[rd_idx];
endmodule

// File: rtl/fir_coef_mem.sv
// Module: coefficient store, one slot per tap, separate from the sample
// store so both tap operands are available in the same cycle.
// Assumes writes and reads may occur in the same cycle; a read sees the
// old value until the write edge.
module fir_coef_mem #(
    parameter int CW       = 8,
    parameter int TAP_LOG2 = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [TAP_LOG2-1:0] waddr,
    input  logic [CW-1:0]       wdata,
    input  logic [TAP_LOG2-1:0] raddr,
    output logic [CW-1:0]       rdata
);
    localparam int DEPTH = 1 << TAP_LOG2;

    logic [CW-1:0] coef_q [DEPTH];

    // Per-slot register with its own decoded write enable.
    for (genvar g = 0; g < DEPTH; g++) begin : g_coef
        always_ff @(posedge clk) begin
            if (!rst_n)
                coef_q[g] <= '0;
            else if (we && (waddr == TAP_LOG2'(g)))
                coef_q[g] <= wdata;
        end
    end

    // Combinational read for the tap being issued.
    always_comb rdata = coef_q[raddr];
endmodule

// File: rtl/fir_tap_seq.sv
// Module: tap loop control. A start moves it from idle into the run phase,
// where a hardware counter issues one tap per cycle with first/last marks;
// it then waits in drain until the pipeline reports the final accumulate.
// Assumes start is only asserted while idle (ready is high).
module fir_tap_seq
    import fir_pkg::*;
#(
    parameter int TAP_LOG2 = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                drain_done,
    output logic                idle,
    output logic                issue_v,
    output logic                issue_first,
    output logic                issue_last,
    output logic [TAP_LOG2-1:0] tap_idx
);
    localparam logic [TAP_LOG2-1:0] LAST_TAP = TAP_LOG2'((1 << TAP_LOG2) - 1);

    seq_state_t          state_q;
    logic [TAP_LOG2-1:0] cnt_q;

    // Phase transitions: idle -> run -> drain -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start) state_q <= ST_RUN;
                ST_RUN:   if (cnt_q == LAST_TAP) state_q <= ST_DRAIN;
                ST_DRAIN: if (drain_done) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Repeat counter: cleared on start, stepped once per issued tap.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (start)             cnt_q <= '0;
        else if (state_q == ST_RUN) cnt_q <= cnt_q + 1'b1;
    end

    // Issue marks derived from phase and counter.
    always_comb begin
        idle        = (state_q == ST_IDLE);
        issue_v     = (state_q == ST_RUN);
        issue_first = issue_v && (cnt_q == '0);
        issue_last  = issue_v && (cnt_q == LAST_TAP);
        tap_idx     = cnt_q;
    end
endmodule

// File: rtl/fir_mac_pipe.sv
// Module: three-stage tap pipeline: operand register, product register,
// accumulator. A tap marked first restarts the sum from zero; a tap marked
// last raises a one-cycle done strobe together with the final sum.
// Assumes ACW >= DW+CW+TAP_LOG2 so the sum cannot overflow.
module fir_mac_pipe #(
    parameter int DW  = 8,
    parameter int CW  = 8,
    parameter int ACW = 19
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_v,
    input  logic           in_first,
    input  logic           in_last,
    input  logic [DW-1:0]  in_smp,
    input  logic [CW-1:0]  in_coef,
    output logic           last_at_acc,
    output logic           done,
    output logic [ACW-1:0] sum
);
    localparam int PW = DW + CW;

    logic signed [DW-1:0]  s_q;
    logic signed [CW-1:0]  c_q;
    logic signed [PW-1:0]  p_q;
    logic signed [ACW-1:0] acc_q;
    logic [ACW-1:0]        p_ext;
    logic                  v1_q, f1_q, l1_q, v2_q, f2_q, l2_q, done_q;

    // Stage 1: capture both operands of the issued tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0; c_q <= '0; v1_q <= 1'b0; f1_q <= 1'b0; l1_q <= 1'b0;
        end else begin
            s_q <= in_smp; c_q <= in_coef;
            v1_q <= in_v; f1_q <= in_first; l1_q <= in_last;
        end
    end

    // Stage 2: signed product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0; v2_q <= 1'b0; f2_q <= 1'b0; l2_q <= 1'b0;
        end else begin
            p_q <= s_q * c_q;
            v2_q <= v1_q; f2_q <= f1_q; l2_q <= l1_q;
        end
    end

    // Sign extension of the product to accumulator width.
    always_comb p_ext = {{(ACW-PW){p_q[PW-1]}}, p_q};

    // Stage 3: accumulate, restarting from zero on the first tap.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (v2_q) acc_q <= (f2_q ? '0 : acc_q) + $signed(p_ext);
    end

    // Done strobe for the cycle after the last accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= v2_q && l2_q;
    end

    always_comb begin
        last_at_acc = v2_q && l2_q;
        done        = done_q;
        sum         = acc_q;
    end
endmodule

// File: rtl/fir_circ_seq.sv
// Module: top of the circular-buffer FIR sequencer. Accepts a sample while
// idle, writes it into the delay line, runs N taps at one per cycle, and
// posts the sum with a one-cycle strobe in the same cycle ready returns.
// Assumes the tap count is a power of two (2**TAP_LOG2).
module fir_circ_seq #(
    parameter int DW       = 8,
    parameter int CW       = 8,
    parameter int TAP_LOG2 = 3,
    localparam int ACW     = DW + CW + TAP_LOG2 + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [DW-1:0]       sample_data,
    output logic                sample_ready,
    input  logic                coef_we,
    input  logic [TAP_LOG2-1:0] coef_addr,
    input  logic [CW-1:0]       coef_data,
    output logic                result_valid,
    output logic [ACW-1:0]      result_data
);
    logic                accept;
    logic                idle;
    logic                issue_v, issue_first, issue_last;
    logic                last_at_acc;
    logic [TAP_LOG2-1:0] tap_idx;
    logic [DW-1:0]       smp_rd;
    logic [CW-1:0]       coef_rd;

    // Handshake: a sample is taken only while the sequencer is idle.
    always_comb begin
        sample_ready = idle;
        accept       = sample_valid && idle;
    end

    fir_delay_line #(.DW(DW), .TAP_LOG2(TAP_LOG2)) dline_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_data (sample_data),
        .rd_ofs  (tap_idx),
        .rd_data (smp_rd)
    );

    fir_coef_mem #(.CW(CW), .TAP_LOG2(TAP_LOG2)) cmem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .waddr (coef_addr),
        .wdata (coef_data),
        .raddr (tap_idx),
        .rdata (coef_rd)
    );

    fir_tap_seq #(.TAP_LOG2(TAP_LOG2)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .drain_done  (last_at_acc),
        .idle        (idle),
        .issue_v     (issue_v),
        .issue_first (issue_first),
        .issue_last  (issue_last),
        .tap_idx     (tap_idx)
    );

    fir_mac_pipe #(.DW(DW), .CW(CW), .ACW(ACW)) mac_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_v        (issue_v),
        .in_first    (issue_first),
        .in_last     (issue_last),
        .in_smp      (smp_rd),
        .in_coef     (coef_rd),
        .last_at_acc (last_at_acc),
        .done        (result_valid),
        .sum         (result_data)
    );
endmodule

// File: rtl/fir_circ_seq_chk.sv
// Module: protocol checker for fir_circ_seq, attached by bind. Tracks the
// cycles since acceptance with its own counter to judge the result latency.
// Assumes the top's default-style parameters are passed through the bind.
module fir_circ_seq_chk #(
    parameter int TAP_LOG2 = 3
) (
    input logic clk,
    input logic rst_n,
    input logic sample_valid,
    input logic sample_ready,
    input logic result_valid
);
    localparam int DEPTH = 1 << TAP_LOG2;
    localparam int CYW   = TAP_LOG2 + 3;

    logic [CYW-1:0] since_q;
    logic           acc_w;

    always_comb acc_w = sample_valid && sample_ready;

    // Cycle counter from acceptance to the result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_q <= '0;
        else if (acc_w)          since_q <= CYW'(1);
        else if (result_valid)   since_q <= '0;
        else if (since_q != '0)  since_q <= since_q + 1'b1;
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_w |=> !sample_ready); // R4

    AST_READY_RISES_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_ready) |-> result_valid); // R4

    AST_RESULT_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> sample_ready); // R4

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R3

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (since_q == CYW'(DEPTH + 3))); // R3
endmodule

bind fir_circ_seq fir_circ_seq_chk #(.TAP_LOG2(TAP_LOG2)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .sample_ready (sample_ready),
    .result_valid (result_valid)
);

// File: tb/fir_circ_seq_tb_top.sv
// Bench: drives samples and coefficients, keeps its own delay-line model,
// and compares each strobed result and its latency against arithmetic.
module fir_circ_seq_tb_top;
    localparam int DW  = 8;
    localparam int CW  = 8;
    localparam int TL  = 3;
    localparam int N   = 1 << TL;
    localparam int ACW = DW + CW + TL + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sample_valid = 1'b0;
    logic [DW-1:0]  sample_data = '0;
    logic           sample_ready;
    logic           coef_we = 1'b0;
    logic [TL-1:0]  coef_addr = '0;
    logic [CW-1:0]  coef_data = '0;
    logic           result_valid;
    logic [ACW-1:0] result_data;

    int checks = 0;
    int errors = 0;
    int hist [N];
    int coef [N];
    int wp = 0;

    always #4 clk = ~clk;

    fir_circ_seq #(.DW(DW), .CW(CW), .TAP_LOG2(TL)) dut_i (
        .clk, .rst_n, .sample_valid, .sample_data, .sample_ready,
        .coef_we, .coef_addr, .coef_data, .result_valid, .result_data
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic int model_y();
        int s = 0;
        for (int k = 0; k < N; k++) s += coef[k] * hist[(wp - k) & (N - 1)];
        return s;
    endfunction

    // Called at a negedge while idle; writes one coefficient slot.
    task automatic write_coef(input int idx, input int val);
        coef_we = 1'b1; coef_addr = TL'(idx); coef_data = CW'(val);
        @(negedge clk);
        coef_we = 1'b0;
        coef[idx] = val;
    endtask

    // Called at a negedge while ready is high. Returns at the negedge of the
    // result cycle. junk > 0 holds valid high with junk data while busy.
    task automatic run_sample(input int x, input int junk, input string req);
        int lat;
        bit busy_ok;
        sample_valid = 1'b1; sample_data = DW'(x);
        @(negedge clk);
        wp = (wp + 1) & (N - 1);
        hist[wp] = x;
        sample_valid = (junk > 0); sample_data = 8'hA5;
        lat = 0; busy_ok = 1'b1;
        while (!result_valid && lat < 100) begin
            if (sample_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
            if (lat >= junk) sample_valid = 1'b0;
        end
        sample_valid = 1'b0;
        chk("R3 latency", lat, N + 2);
        chk("R4 ready low while busy", busy_ok, 1);
        chk("R4 ready high in result cycle", sample_ready, 1);
        chk(req, longint'($signed(result_data)), model_y());
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        int v;
        for (int i = 0; i < N; i++) begin hist[i] = 0; coef[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", sample_ready, 1);
        chk("R1 result_valid after reset", result_valid, 0);

        // R1: zero coefficients and empty line give a zero sum.
        run_sample(77, 0, "R1 zero state result");
        @(negedge clk);
        chk("R3 pulse one cycle", result_valid, 0);

        // R7/R2/R5: impulse response reads back every coefficient, then wraps out.
        for (int k = 0; k < N; k++) write_coef(k, 3 * k - 10);
        run_sample(1, 0, "R7 impulse tap 0");
        for (int k = 1; k <= N + 1; k++) run_sample(0, 0, "R5 impulse walk");
        chk("R5 impulse gone", longint'($signed(result_data)), 0);

        // R2/R5: sweep of computed samples across several coefficient sets.
        v = 13;
        for (int set = 0; set < 4; set++) begin
            for (int k = 0; k < N; k++) write_coef(k, ((k * 37 + set * 53) % 256) - 128);
            for (int i = 0; i < 3 * N; i++) begin
                v = (v * 29 + 71) % 256;
                run_sample(v - 128, 0, "R2 sweep");
            end
        end

        // R8: full-scale negative operands, exact positive sum 131072.
        for (int k = 0; k < N; k++) write_coef(k, -128);
        for (int i = 0; i < N; i++) run_sample(-128, 0, "R8 full scale fill");
        chk("R8 full scale sum", longint'($signed(result_data)), 131072);
        run_sample(127, 0, "R8 mixed sign");

        // R6: samples presented in the result cycle, back to back.
        for (int k = 0; k < N; k++) write_coef(k, k + 1);
        for (int i = 0; i < 2 * N; i++) run_sample(i * 11 - 60, 0, "R6 back to back");

        // R4: valid held with junk while busy is ignored.
        for (int i = 0; i < N + 2; i++) run_sample(i - 4, 3, "R4 junk ignored");

        // R7: rewrite one coefficient between samples.
        @(negedge clk);
        write_coef(2, 100);
        run_sample(9, 0, "R7 rewritten coef");
        write_coef(N - 1, -77);
        run_sample(-5, 0, "R7 last slot rewrite");

        report();
    end
endmodule